// File: doc/BRIEF.md
# Four-Phase Control Register Target

This block is the responding end of a simple four-phase control-register port. A master talks to it through four single-bit strobes and a 16-bit input bus: one strobe captures an address, one captures a write value, one asks for a read and one commits a write. The target answers every accepted strobe with an acknowledge. It keeps the acknowledge high until the master withdraws the strobe, and then drops it, which closes the handshake.

Inside the target is a small bank of 16-bit registers, each with its own reset value. The address and the write value are captured in separate handshakes. A later write handshake, which carries nothing on the bus, stores the captured value into the captured location. A read handshake copies the addressed register onto the output bus. The output stays there until the next read.

The delay between accepting a strobe and raising acknowledge is set on an input (0 to 7 cycles), so a master's wait loop can be exercised with different latencies.

Top module: `cr_port_target`

## Requirements
- R1: A handshake with only `cap_addr` high loads `din` into the captured address. Later reads and writes use that address.
- R2: A handshake with only `cap_data` high loads `din` into the captured write value. The value stays captured across any number of later write handshakes.
- R3: A handshake with only `wr_cmd` high stores the captured write value into the register at the captured address. The level of `din` during that handshake has no effect.
- R4: A handshake with only `rd_cmd` high drives the addressed register onto `dout`. `dout` does not change while `ack` stays high.
- R5: `ack` rises only in answer to an accepted strobe and stays high while any strobe is high. It falls on the first clock edge at which all four strobes are sampled low.
- R6: After reset, `ack` and `dout` are 0. Register i reads back (RST_BASE + i*RST_STEP) mod 2^16 until it is written.
- R7: When a single strobe is first sampled at clock edge k with `ack_wait` = N, `ack` is high right after edge k+N.
- R8: Each strobe acts once per handshake, on its first sampled cycle. A change on `din` while the strobe is held does not alter what was captured.
- R9: A captured address at or above NREGS makes a write have no effect on any register, and a read returns 0.
- R10: When two or more strobes are high together while the target is idle, nothing is captured, written or read, and `ack` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_addr | input | 1 | Strobe: capture `din` as the address |
| cap_data | input | 1 | Strobe: capture `din` as the write value |
| rd_cmd | input | 1 | Strobe: read the addressed register |
| wr_cmd | input | 1 | Strobe: commit the captured value |
| din | input | DW (16) | Address or write value |
| ack_wait | input | WAIT_W (3) | Cycles between strobe acceptance and acknowledge |
| ack | output | 1 | Handshake acknowledge |
| dout | output | DW (16) | Read data |

## Verification
The bench builds the target with NREGS = 6, RST_BASE = 0x1200 and RST_STEP = 0x0135. With these values, two of the eight swept addresses (6 and 7) lie outside the bank. The sweep therefore covers both in-range and out-of-range behaviour, and every reset value is distinct and easy to compute. Every address is read and written with a different `ack_wait`, so all eight acknowledge latencies are measured against the expected N+1 sampling points. Held strobes with a changing bus and combined strobes are applied on top of the sweep.

// File: rtl/cr_tgt_pkg.sv
package cr_tgt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ACK
    } hs_state_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_ADDR,
        CMD_DATA,
        CMD_READ,
        CMD_WRITE
    } cmd_e;

endpackage

// File: rtl/cr_strobe_decode.sv
module cr_strobe_decode
    import cr_tgt_pkg::*;
(
    input  logic [3:0] strb,
    output cmd_e       cmd,
    output logic       any_strb
);
    // strb bit order: 0 capture address, 1 capture data, 2 read, 3 write
    always_comb begin
        any_strb = |strb;
        unique case (strb)
            4'b0001: cmd = CMD_ADDR;
            4'b0010: cmd = CMD_DATA;
            4'b0100: cmd = CMD_READ;
            4'b1000: cmd = CMD_WRITE;
            default: cmd = CMD_NONE;
        endcase
    end
endmodule

// File: rtl/cr_hs_ctrl.sv
module cr_hs_ctrl
    import cr_tgt_pkg::*;
#(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic              any_strb,
    input  logic [WAIT_W-1:0] ack_wait,
    output logic              fire,
    output logic              ack,
    output logic              busy
);
    typedef struct packed {
        hs_state_e         state;
        logic [WAIT_W-1:0] cnt;
    } hs_t;

    hs_t hs_d, hs_q;

    always_comb begin
        hs_d = hs_q;
        fire = (hs_q.state == ST_IDLE) && (cmd != CMD_NONE);
        unique case (hs_q.state)
            ST_IDLE: begin
                if (fire) begin
                    if (ack_wait == '0) begin
                        hs_d.state = ST_ACK;
                    end else begin
                        hs_d.state = ST_WAIT;
                        hs_d.cnt   = ack_wait;
                    end
                end
            end
            ST_WAIT: begin
                if (hs_q.cnt == WAIT_W'(1)) hs_d.state = ST_ACK;
                else                        hs_d.cnt   = hs_q.cnt - WAIT_W'(1);
            end
            ST_ACK: begin
                if (!any_strb) hs_d.state = ST_IDLE;
            end
            default: hs_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q.state <= ST_IDLE;
            hs_q.cnt   <= '0;
        end else begin
            hs_q <= hs_d;
        end
    end

    assign ack  = (hs_q.state == ST_ACK);
    assign busy = (hs_q.state != ST_IDLE);
endmodule

// File: rtl/cr_reg_bank.sv
module cr_reg_bank #(
    parameter int          DW       = 16,
    parameter int          NREGS    = 8,
    parameter int unsigned RST_BASE = 32'h0000_A000,
    parameter int unsigned RST_STEP = 32'h0000_0111
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam logic [DW-1:0] LIMIT = DW'(NREGS);

    logic [DW-1:0] mem_d [NREGS];
    logic [DW-1:0] mem_q [NREGS];
    logic          in_range;

    assign in_range = (addr < LIMIT);

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam logic [DW-1:0] RV = DW'(RST_BASE + g * RST_STEP);

        always_comb begin
            mem_d[g] = mem_q[g];
            if (we && in_range && (addr == DW'(g))) mem_d[g] = wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) mem_q[g] <= RV;
            else        mem_q[g] <= mem_d[g];
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (in_range && (addr == DW'(i))) rdata = mem_q[i];
        end
    end
endmodule

// File: rtl/cr_port_target.sv
module cr_port_target
    import cr_tgt_pkg::*;
#(
    parameter int          DW       = 16,
    parameter int          WAIT_W   = 3,
    parameter int          NREGS    = 8,
    parameter int unsigned RST_BASE = 32'h0000_A000,
    parameter int unsigned RST_STEP = 32'h0000_0111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_addr,
    input  logic              cap_data,
    input  logic              rd_cmd,
    input  logic              wr_cmd,
    input  logic [DW-1:0]     din,
    input  logic [WAIT_W-1:0] ack_wait,
    output logic              ack,
    output logic [DW-1:0]     dout
);
    typedef struct packed {
        logic [DW-1:0] addr;
        logic [DW-1:0] data;
        logic [DW-1:0] dout;
    } lat_t;

    lat_t          lat_d, lat_q;
    logic [3:0]    strb;
    cmd_e          cmd;
    logic          any_strb;
    logic          fire;
    logic          busy;
    logic          we;
    logic          rd_fire;
    logic [DW-1:0] rdata;
    logic [DW-1:0] addr_cur;

    assign strb     = {wr_cmd, rd_cmd, cap_data, cap_addr};
    assign addr_cur = lat_q.addr;

    cr_strobe_decode u_dec (
        .strb     (strb),
        .cmd      (cmd),
        .any_strb (any_strb)
    );

    cr_hs_ctrl #(.WAIT_W(WAIT_W)) u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .any_strb (any_strb),
        .ack_wait (ack_wait),
        .fire     (fire),
        .ack      (ack),
        .busy     (busy)
    );

    cr_reg_bank #(
        .DW       (DW),
        .NREGS    (NREGS),
        .RST_BASE (RST_BASE),
        .RST_STEP (RST_STEP)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .addr  (lat_q.addr),
        .wdata (lat_q.data),
        .rdata (rdata)
    );

    always_comb begin
        lat_d   = lat_q;
        we      = fire && (cmd == CMD_WRITE);
        rd_fire = fire && (cmd == CMD_READ);
        if (fire) begin
            unique case (cmd)
                CMD_ADDR: lat_d.addr = din;
                CMD_DATA: lat_d.data = din;
                CMD_READ: lat_d.dout = rdata;
                default:  lat_d      = lat_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign dout = lat_q.dout;
endmodule

// File: rtl/cr_port_target_chk.sv
module cr_port_target_chk #(
    parameter int DW     = 16,
    parameter int WAIT_W = 3,
    parameter int NREGS  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        strb,
    input logic              ack,
    input logic              busy,
    input logic [DW-1:0]     dout,
    input logic [WAIT_W-1:0] ack_wait,
    input logic              rd_fire,
    input logic [DW-1:0]     addr_cur
);
    p_ack_drop_after_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> ($past(strb) == 4'b0000));

    p_multi_strobe_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ($countones(strb) > 1)) |=> (!busy && !ack));

    p_dout_held_under_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(ack)) |-> $stable(dout));

    p_zero_wait_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ($countones(strb) == 1) && (ack_wait == '0)) |=> ack);

    p_oob_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && (addr_cur >= DW'(NREGS))) |=> (dout == '0));
endmodule

bind cr_port_target cr_port_target_chk #(
    .DW     (DW),
    .WAIT_W (WAIT_W),
    .NREGS  (NREGS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .ack      (ack),
    .busy     (busy),
    .dout     (dout),
    .ack_wait (ack_wait),
    .rd_fire  (rd_fire),
    .addr_cur (addr_cur)
);

// File: tb/test_cr_port_target.sv
module test_cr_port_target;
    localparam int DW    = 16;
    localparam int NREGS = 6;
    localparam int unsigned BASE = 32'h1200;
    localparam int unsigned STEP = 32'h0135;

    localparam logic [3:0] S_ADDR = 4'b0001;
    localparam logic [3:0] S_DATA = 4'b0010;
    localparam logic [3:0] S_RD   = 4'b0100;
    localparam logic [3:0] S_WR   = 4'b1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cap_addr = 1'b0, cap_data = 1'b0, rd_cmd = 1'b0, wr_cmd = 1'b0;
    logic [DW-1:0] din = '0;
    logic [2:0]    ack_wait = '0;
    logic          ack;
    logic [DW-1:0] dout;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    logic [DW-1:0] model [8];

    always #2 clk = ~clk;

    cr_port_target #(
        .NREGS    (NREGS),
        .RST_BASE (BASE),
        .RST_STEP (STEP)
    ) i_cr_port_target (
        .clk(clk), .rst_n(rst_n), .cap_addr(cap_addr), .cap_data(cap_data),
        .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .din(din), .ack_wait(ack_wait),
        .ack(ack), .dout(dout)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rstv(input int i);
        return DW'(BASE + i * STEP);
    endfunction

    // one full handshake; d2 replaces din while the strobe is held for 'hold' cycles
    task automatic hs(input logic [3:0] s, input logic [DW-1:0] d, input logic [DW-1:0] d2,
                      input int hold, input logic [2:0] w);
        int lat;
        bit got;
        logic [DW-1:0] held;
        @(negedge clk);
        ack_wait = w;
        din = d;
        {wr_cmd, rd_cmd, cap_data, cap_addr} = s;
        lat = 0;
        got = 0;
        for (int i = 0; i < 20 && !got; i++) begin
            @(negedge clk);
            lat++;
            if (ack) got = 1;
        end
        chk(got, "R5 ack rises", 32'(got), 32'd1);
        chk(lat == int'(w) + 1, "R7 ack latency", 32'(lat), 32'(int'(w) + 1));
        held = dout;
        din = d2;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(ack, "R5 ack held while strobe high", 32'(ack), 32'd1);
            chk(dout == held, "R4 dout stable under ack", 32'(dout), 32'(held));
        end
        {wr_cmd, rd_cmd, cap_data, cap_addr} = 4'b0000;
        @(negedge clk);
        chk(!ack, "R5 ack drops after release", 32'(ack), 32'd0);
    endtask

    task automatic do_read(input int a, input logic [2:0] w, input int hold, input string req);
        hs(S_ADDR, DW'(a), 16'h0F0F, 0, w);
        hs(S_RD, 16'hC3C3, 16'h3C3C, hold, 3'(int'(w) + 3));
        chk(dout == model[a], req, 32'(dout), 32'(model[a]));
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] v, input logic [2:0] w);
        hs(S_ADDR, DW'(a), 16'h0, 0, w);
        hs(S_DATA, v, 16'h0, 0, w);
        hs(S_WR, 16'hFFFF, 16'hAAAA, 0, w);   // R3: din carries junk during the commit
        if (a < NREGS) model[a] = v;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) model[i] = (i < NREGS) ? rstv(i) : '0;
        repeat (3) @(negedge clk);
        chk(ack == 1'b0, "R6 ack after reset", 32'(ack), 32'd0);
        chk(dout == '0, "R6 dout after reset", 32'(dout), 32'd0);
        rst_n = 1'b1;

        // R6 / R1 / R4 / R9: reset values across all addresses, all latencies
        for (int a = 0; a < 8; a++) do_read(a, 3'(a), 2, "R6 R1 reset value / R9 oob read");

        // R3 / R9: write a pattern everywhere, then read back
        for (int a = 0; a < 8; a++) do_write(a, DW'(a * 32'h1111) ^ 16'h5A5A, 3'(7 - a));
        for (int a = 0; a < 8; a++) do_read(a, 3'(a + 1), 1, "R3 written value / R9 oob write ignored");

        // R8: bus changes while capture strobe held
        hs(S_ADDR, 16'd2, 16'd4, 3, 3'd1);
        hs(S_DATA, 16'h1234, 16'hBEEF, 3, 3'd0);
        hs(S_WR, 16'h0000, 16'h5555, 3, 3'd2);
        model[2] = 16'h1234;
        hs(S_RD, 16'h0, 16'h0, 0, 3'd0);
        chk(dout == 16'h1234, "R8 held strobe acts once", 32'(dout), 32'h1234);

        // R2: the captured value stays for a second commit elsewhere
        hs(S_ADDR, 16'd5, 16'd0, 0, 3'd4);
        hs(S_WR, 16'h7777, 16'h0, 0, 3'd4);
        model[5] = 16'h1234;
        do_read(5, 3'd2, 0, "R2 captured value reused");

        // R10: combined strobes do nothing
        hs(S_ADDR, 16'd1, 16'd1, 0, 3'd0);
        @(negedge clk);
        din = 16'd3;
        ack_wait = 3'd0;
        {wr_cmd, rd_cmd, cap_data, cap_addr} = 4'b0011;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!ack, "R10 no ack on addr+data", 32'(ack), 32'd0);
        end
        {wr_cmd, rd_cmd, cap_data, cap_addr} = 4'b1100;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!ack, "R10 no ack on read+write", 32'(ack), 32'd0);
        end
        {wr_cmd, rd_cmd, cap_data, cap_addr} = 4'b0000;
        hs(S_RD, 16'h0, 16'h0, 0, 3'd1);
        chk(dout == model[1], "R10 address and register unchanged", 32'(dout), 32'(model[1]));
        do_read(3, 3'd0, 0, "R10 no stray write");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule